// File: doc/BRIEF.md
# Hot-plug Slot Command Completion Controller

This block holds the slot control word of a downstream port that supports hot-plug, together with the Command Completed flag of its slot status word. Software writes the 16-bit control word. For each write, the block decides whether the write is a hot-plug command. A command carries the control field group, bits 11:6, to a downstream power and indicator controller over a valid/ready channel. The Command Completed flag is raised only once the controller has accepted that transfer.

The `QUIRK_MODE` parameter picks one of two decision rules. When it is 0, every write on a capable port is a command. When it is 1, a write is a command only if it changes at least one of the four control fields: interlock control (bit 11), power controller control (bit 10), power indicator control (bits 9:8) and attention indicator control (bits 7:6). A write that alters only notification enables or other bits is then silently absorbed. `HP_CAPABLE` = 0 models a port without hot-plug support. `NO_CMD_CMPL` = 1 models a port that advertises no completion support: deliveries still take place, but the flag never rises.

Software can write again while a delivery is still outstanding. The block then keeps a single pending command that carries the latest field values, and it raises the flag once, after the last of these deliveries. A one-cycle interrupt pulse marks each rise of the flag while both of its enables are set.

Top module: `hp_slot_cmd_ctrl`

## Requirements
- R1: After reset, `slot_ctrl` reads 0, `slot_sts` reads 0, `dn_valid` is low and `cc_irq` is low.
- R2: A write with `ctl_wr_en` high updates `slot_ctrl` to `ctl_wr_data` on the next cycle, whatever the mode.
- R3: With `QUIRK_MODE`=0 on a capable port, every control write produces a delivery, and it eventually sets `slot_sts[4]` unless a later write is merged into the same pending command.
- R4: With `QUIRK_MODE`=1, a write is a command only when `ctl_wr_data[11:6]` differs from the current `slot_ctrl[11:6]`.
- R5: With `QUIRK_MODE`=1, a write that changes only bits outside 11:6 (for example the enables at bits 5:0 and 12) starts no delivery and never sets `slot_sts[4]`.
- R6: With `HP_CAPABLE`=0, no write starts a delivery, and `slot_sts[4]` stays 0.
- R7: With `NO_CMD_CMPL`=1, deliveries still occur but `slot_sts[4]` is never set.
- R8: A delivery presents `dn_data` equal to `slot_ctrl[11:6]` as of the command. `dn_valid` and `dn_data` then stay stable until a cycle with `dn_ready` high.
- R9: `slot_sts[4]` rises only on the cycle after the handshake that completes the last outstanding delivery. A command written while a delivery is in flight becomes one pending command that carries the latest fields.
- R10: Writing `slot_sts` with bit 4 set clears the flag. If a completion and a clear happen in the same cycle, the flag is set.
- R11: `cc_irq` is high for one cycle, together with the rise of `slot_sts[4]`, when `slot_ctrl[4]` (completion interrupt enable) and `slot_ctrl[5]` (hot-plug interrupt enable) were both set. In every other cycle it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_en | input | 1 | Write strobe for the slot control word |
| ctl_wr_data | input | 16 | Slot control write data |
| sts_wr_en | input | 1 | Write strobe for the slot status word |
| sts_wr_data | input | 16 | Status write data; a 1 in bit 4 clears the completion flag |
| slot_ctrl | output | 16 | Current slot control word |
| slot_sts | output | 16 | Slot status word; bit 4 is the completion flag, the other bits are 0 |
| dn_valid | output | 1 | Delivery to the downstream controller is offered |
| dn_data | output | 6 | Control field group {bit 11, bit 10, bits 9:8, bits 7:6} |
| dn_ready | input | 1 | Downstream controller accepts the delivery |
| cc_irq | output | 1 | One-cycle completion interrupt pulse |

## Verification
Suppose the command decision goes wrong, for example a quirk-mode comparison against the wrong bits or a write that is not treated as a command on a capable port. The fault shows one cycle after the write: `dn_valid` rises when it should not, or stays low when it should rise. Suppose instead the pending marker is lost or stuck. The completion flag then rises early, late or twice, and the error is visible on the cycle after the deciding handshake. A bad data capture shows up on `dn_data` for the whole time `dn_valid` is held. Because the bench compares every output against a cycle model in every cycle, each such fault is reported within a cycle of the stimulus that exposes it.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int SLOT_W   = 16;
  localparam int FLD_LSB  = 6;
  localparam int FLD_MSB  = 11;
  localparam int FLD_W    = FLD_MSB - FLD_LSB + 1;
  localparam int CC_BIT   = 4;  // completion flag in status
  localparam int CCIE_BIT = 4;  // completion interrupt enable in control
  localparam int HPIE_BIT = 5;  // hot-plug interrupt enable in control

  typedef logic [SLOT_W-1:0] slot_word_t;
  typedef logic [FLD_W-1:0]  cmd_fld_t;

  // Extract the control field group that a downstream controller acts on.
  function automatic cmd_fld_t ctl_fields(input slot_word_t w);
    return w[FLD_MSB:FLD_LSB];
  endfunction

  // Decide whether a control write forms a hot-plug command.
  function automatic logic write_is_cmd(input logic quirk, input logic capable,
                                        input slot_word_t old_w, input slot_word_t new_w);
    if (!capable)    return 1'b0;
    else if (!quirk) return 1'b1;
    else             return ctl_fields(old_w) != ctl_fields(new_w);
  endfunction

  // Status word as seen by software: only the completion flag is modelled.
  function automatic slot_word_t status_word(input logic cc);
    slot_word_t w;
    w = '0;
    w[CC_BIT] = cc;
    return w;
  endfunction
endpackage

// File: rtl/hp_cmd_detect.sv
module hp_cmd_detect
  import hp_slot_pkg::*;
#(
  parameter bit QUIRK_MODE = 1'b0,
  parameter bit HP_CAPABLE = 1'b1
) (
  input  logic       wr_en,
  input  slot_word_t cur_word,
  input  slot_word_t new_word,
  output logic       cmd_evt,
  output cmd_fld_t   new_fld
);
  always_comb begin
    cmd_evt = wr_en && write_is_cmd(QUIRK_MODE, HP_CAPABLE, cur_word, new_word);
    new_fld = ctl_fields(new_word);
  end
endmodule

// File: rtl/hp_cmd_deliver.sv
module hp_cmd_deliver
  import hp_slot_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_evt,
  input  cmd_fld_t new_fld,
  input  cmd_fld_t cur_fld,
  input  logic     dn_ready,
  output logic     dn_valid,
  output cmd_fld_t dn_data,
  output logic     done_evt
);
  logic pend_q;
  logic hs;
  logic issue;

  always_comb begin
    hs       = dn_valid && dn_ready;
    issue    = cmd_evt ? (!dn_valid || hs) : (hs && pend_q);
    done_evt = hs && !pend_q && !cmd_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (issue) begin
        dn_valid <= 1'b1;
        dn_data  <= cmd_evt ? new_fld : cur_fld;
        pend_q   <= 1'b0;
      end else if (hs) begin
        dn_valid <= 1'b0;
      end
      if (cmd_evt && dn_valid && !hs) pend_q <= 1'b1;
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data)); // R8

  AST_PEND_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> dn_valid); // R9
endmodule

// File: rtl/hp_cmd_status.sv
module hp_cmd_status
  import hp_slot_pkg::*;
#(
  parameter bit NO_CMD_CMPL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done_evt,
  input  logic       sts_wr_en,
  input  slot_word_t sts_wr_data,
  input  logic       ccie,
  input  logic       hpie,
  output logic       cc_flag,
  output logic       cc_irq
);
  localparam slot_word_t CC_MASK = slot_word_t'(1) << CC_BIT;
  logic set_evt;
  logic clr_evt;

  always_comb begin
    set_evt = done_evt && !NO_CMD_CMPL;
    clr_evt = sts_wr_en && |(sts_wr_data & CC_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc_flag <= 1'b0;
      cc_irq  <= 1'b0;
    end else begin
      if (set_evt)      cc_flag <= 1'b1;
      else if (clr_evt) cc_flag <= 1'b0;
      cc_irq <= set_evt && !cc_flag && ccie && hpie;
    end
  end

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt && !done_evt |=> !cc_flag); // R10

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && !NO_CMD_CMPL |=> cc_flag); // R10

  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cc_irq |-> cc_flag && !$past(cc_flag)); // R11

  AST_NO_FLAG_WHEN_UNSUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    NO_CMD_CMPL |-> !cc_flag); // R7
endmodule

// File: rtl/hp_slot_cmd_ctrl.sv
module hp_slot_cmd_ctrl
  import hp_slot_pkg::*;
#(
  parameter bit QUIRK_MODE  = 1'b0,
  parameter bit HP_CAPABLE  = 1'b1,
  parameter bit NO_CMD_CMPL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_en,
  input  logic [SLOT_W-1:0] ctl_wr_data,
  input  logic              sts_wr_en,
  input  logic [SLOT_W-1:0] sts_wr_data,
  output logic [SLOT_W-1:0] slot_ctrl,
  output logic [SLOT_W-1:0] slot_sts,
  output logic              dn_valid,
  output logic [FLD_W-1:0]  dn_data,
  input  logic              dn_ready,
  output logic              cc_irq
);
  slot_word_t ctrl_q;
  logic       cmd_evt;
  cmd_fld_t   new_fld;
  logic       done_evt;
  logic       cc_flag;

  always_ff @(posedge clk) begin
    if (!rst_n)         ctrl_q <= '0;
    else if (ctl_wr_en) ctrl_q <= ctl_wr_data;
  end

  hp_cmd_detect #(.QUIRK_MODE(QUIRK_MODE), .HP_CAPABLE(HP_CAPABLE)) u_detect (
    .wr_en    (ctl_wr_en),
    .cur_word (ctrl_q),
    .new_word (ctl_wr_data),
    .cmd_evt  (cmd_evt),
    .new_fld  (new_fld)
  );

  hp_cmd_deliver u_deliver (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_evt  (cmd_evt),
    .new_fld  (new_fld),
    .cur_fld  (ctl_fields(ctrl_q)),
    .dn_ready (dn_ready),
    .dn_valid (dn_valid),
    .dn_data  (dn_data),
    .done_evt (done_evt)
  );

  hp_cmd_status #(.NO_CMD_CMPL(NO_CMD_CMPL)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_evt    (done_evt),
    .sts_wr_en   (sts_wr_en),
    .sts_wr_data (sts_wr_data),
    .ccie        (ctrl_q[CCIE_BIT]),
    .hpie        (ctrl_q[HPIE_BIT]),
    .cc_flag     (cc_flag),
    .cc_irq      (cc_irq)
  );

  always_comb begin
    slot_ctrl = ctrl_q;
    slot_sts  = status_word(cc_flag);
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en |=> slot_ctrl == $past(ctl_wr_data)); // R2

  AST_NOCAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !HP_CAPABLE |-> !dn_valid && !slot_sts[CC_BIT]); // R6

  AST_CC_AFTER_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_sts[CC_BIT]) |-> $past(dn_valid && dn_ready)); // R9

  AST_QUIRK_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    QUIRK_MODE && !dn_valid && ctl_wr_en && ctl_wr_data[FLD_MSB:FLD_LSB] == slot_ctrl[FLD_MSB:FLD_LSB]
    |=> !dn_valid); // R5
endmodule

// File: tb/hp_slot_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module hp_slot_cmd_ctrl_bench;
  localparam int NI = 4;
  localparam int NCYC = 6000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        ctl_wr_en = 1'b0, sts_wr_en = 1'b0, dn_ready = 1'b0;
  logic [15:0] ctl_wr_data = '0, sts_wr_data = '0;

  logic [15:0] o_ctrl [NI];
  logic [15:0] o_sts  [NI];
  logic        o_vld  [NI];
  logic [5:0]  o_dat  [NI];
  logic        o_irq  [NI];

  // instance configuration: 0 conforming, 1 quirk, 2 not capable, 3 no completion support
  localparam bit CQ [NI] = '{1'b0, 1'b1, 1'b0, 1'b0};
  localparam bit CH [NI] = '{1'b1, 1'b1, 1'b0, 1'b1};
  localparam bit CN [NI] = '{1'b0, 1'b0, 1'b0, 1'b1};
  string tag [NI] = '{"R3", "R4 R5", "R6", "R7"};

  hp_slot_cmd_ctrl #(.QUIRK_MODE(1'b0), .HP_CAPABLE(1'b1), .NO_CMD_CMPL(1'b0)) u_hp_slot_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .slot_ctrl(o_ctrl[0]), .slot_sts(o_sts[0]),
    .dn_valid(o_vld[0]), .dn_data(o_dat[0]), .dn_ready(dn_ready), .cc_irq(o_irq[0]));
  hp_slot_cmd_ctrl #(.QUIRK_MODE(1'b1), .HP_CAPABLE(1'b1), .NO_CMD_CMPL(1'b0)) u_quirk (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .slot_ctrl(o_ctrl[1]), .slot_sts(o_sts[1]),
    .dn_valid(o_vld[1]), .dn_data(o_dat[1]), .dn_ready(dn_ready), .cc_irq(o_irq[1]));
  hp_slot_cmd_ctrl #(.QUIRK_MODE(1'b0), .HP_CAPABLE(1'b0), .NO_CMD_CMPL(1'b0)) u_nocap (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .slot_ctrl(o_ctrl[2]), .slot_sts(o_sts[2]),
    .dn_valid(o_vld[2]), .dn_data(o_dat[2]), .dn_ready(dn_ready), .cc_irq(o_irq[2]));
  hp_slot_cmd_ctrl #(.QUIRK_MODE(1'b0), .HP_CAPABLE(1'b1), .NO_CMD_CMPL(1'b1)) u_nocc (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .slot_ctrl(o_ctrl[3]), .slot_sts(o_sts[3]),
    .dn_valid(o_vld[3]), .dn_data(o_dat[3]), .dn_ready(dn_ready), .cc_irq(o_irq[3]));

  // reference state: value each output holds after the coming clock edge
  logic [15:0] m_ctrl [NI];
  logic        m_vld  [NI];
  logic        m_pend [NI];
  logic [5:0]  m_dat  [NI];
  logic        m_cc   [NI];
  logic        m_irq  [NI];

  int n_checks = 0, n_fail = 0;
  int n_cc_rises = 0, n_irq = 0;
  bit finished = 1'b0;

  function automatic logic [5:0] grp(input logic [15:0] w);
    return {w[11], w[10], w[9:8], w[7:6]};
  endfunction

  // R3 R4 R6: does this write count as a command for instance i
  function automatic bit counts(input int i, input logic [15:0] oldw, input logic [15:0] neww);
    if (CH[i] == 1'b0) return 1'b0;
    if (CQ[i] == 1'b0) return 1'b1;
    return grp(oldw) != grp(neww);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NI; i++) begin
      m_ctrl[i] = '0; m_vld[i] = 1'b0; m_pend[i] = 1'b0;
      m_dat[i] = '0; m_cc[i] = 1'b0; m_irq[i] = 1'b0;
    end
  endtask

  // advance the reference by one edge given the inputs now applied
  task automatic model_step();
    for (int i = 0; i < NI; i++) begin
      bit cmd, accepted, last, sets, clr;
      cmd      = ctl_wr_en && counts(i, m_ctrl[i], ctl_wr_data);
      accepted = m_vld[i] && dn_ready;
      last     = accepted && !m_pend[i] && !cmd;            // R9
      sets     = last && !CN[i];                              // R7
      clr      = sts_wr_en && sts_wr_data[4];                 // R10
      m_irq[i] = sets && !m_cc[i] && m_ctrl[i][4] && m_ctrl[i][5]; // R11
      if (sets) n_cc_rises += (m_cc[i] ? 0 : 1);
      m_cc[i]  = sets ? 1'b1 : (clr ? 1'b0 : m_cc[i]);
      case ({m_vld[i], accepted, cmd})
        3'b001, 3'b111: begin m_vld[i] = 1'b1; m_dat[i] = grp(ctl_wr_data); m_pend[i] = 1'b0; end
        3'b101:         m_pend[i] = 1'b1;
        3'b110: begin
          if (m_pend[i]) begin
            m_dat[i] = grp(ctl_wr_en ? ctl_wr_data : m_ctrl[i]);
            m_pend[i] = 1'b0;
          end else m_vld[i] = 1'b0;
        end
        default: ;
      endcase
      if (ctl_wr_en) m_ctrl[i] = ctl_wr_data;                 // R2
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < NI; i++) begin
      check({"R2 ", tag[i]}, o_ctrl[i], m_ctrl[i]);
      check({"R9 R10 ", tag[i]}, o_sts[i], {11'b0, m_cc[i], 4'b0});
      check({"R8 ", tag[i]}, {15'b0, o_vld[i]}, {15'b0, m_vld[i]});
      if (m_vld[i]) check({"R8 ", tag[i]}, {10'b0, o_dat[i]}, {10'b0, m_dat[i]});
      check({"R11 ", tag[i]}, {15'b0, o_irq[i]}, {15'b0, m_irq[i]});
      if (o_irq[i]) n_irq++;
    end
  endtask

  task automatic cycle(input bit we, input logic [15:0] wd, input bit se,
                       input logic [15:0] sd, input bit rdy);
    ctl_wr_en = we; ctl_wr_data = wd; sts_wr_en = se; sts_wr_data = sd; dn_ready = rdy;
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] w;
    process::self().srandom(32'h5107_c0de);
    model_reset();
    repeat (4) @(negedge clk);
    for (int i = 0; i < NI; i++) begin          // R1
      check("R1 ctrl", o_ctrl[i], 16'h0);
      check("R1 sts", o_sts[i], 16'h0);
      check("R1 valid/irq", {14'b0, o_vld[i], o_irq[i]}, 16'h0);
    end
    rst_n = 1'b1;

    // directed: enables only (bits 4,5,12) - quirk ignores it (R5), conforming delivers (R3)
    cycle(1, 16'h1030, 0, 0, 0);
    cycle(0, 0, 0, 0, 0);
    check("R5 quirk no delivery", {15'b0, o_vld[1]}, 16'h0);
    check("R3 conforming delivery", {15'b0, o_vld[0]}, 16'h1);
    cycle(0, 0, 0, 0, 1);
    check("R11 irq on completion", {15'b0, o_irq[0]}, 16'h1);
    // directed: control field change while busy, merged into one pending command (R9)
    cycle(1, 16'h1430, 0, 0, 0);
    cycle(1, 16'h1730, 0, 0, 0);
    cycle(1, 16'h17F0, 0, 0, 0);
    cycle(0, 0, 0, 0, 1);
    check("R9 pending reissue data", {10'b0, o_dat[1]}, {10'b0, grp(16'h17F0)});
    cycle(0, 0, 1, 16'h0010, 1);
    check("R10 set wins over clear", o_sts[1], 16'h0010);
    cycle(0, 0, 1, 16'h0010, 0);
    check("R10 clear", o_sts[1], 16'h0000);

    // constrained random with periods of backpressure
    for (int c = 0; c < NCYC; c++) begin
      bit we, se, rdy;
      we = ($urandom_range(0, 9) < 3);
      w  = o_ctrl[1];
      case ($urandom_range(0, 3))
        0: w = $urandom;
        1: w = {w[15:13], ~w[12], w[11:6], 6'($urandom)};   // enables only
        2: w = {w[15:12], 6'($urandom), w[5:0]};            // control fields only
        default: w = w;                                      // rewrite unchanged
      endcase
      se  = ($urandom_range(0, 9) < 2);
      rdy = ((c % 150) < 40) ? 1'b0 : $urandom_range(0, 1) == 1;
      cycle(we, w, se, 16'($urandom), rdy);
    end

    n_checks++;
    if (n_cc_rises == 0 || n_irq == 0) begin
      n_fail++;
      $display("FAIL R3 R11 coverage actual=%0d/%0d expected nonzero", n_cc_rises, n_irq);
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule